// File: doc/BRIEF.md
# DE-Only Sync Regenerator

Some video sources deliver pixels framed by nothing but a Data Enable level, with no horizontal or vertical sync of their own. This block rebuilds line and frame timing for such a source. It counts how many consecutive pixels arrive with DE low. When that run reaches a programmable horizontal gap length it emits a horizontal sync strobe. When the run reaches a larger programmable vertical gap length it emits a vertical sync strobe. On the first DE-high pixel after such a gap it marks the start of a new line, and where the gap was long enough, the start of a new frame.

The two gap lengths are plain configuration inputs and may be changed while the block runs. A horizontal gap of at least 2 that is strictly shorter than the vertical gap is a valid setting. Any other setting raises an error flag and mutes every generated pulse until the setting becomes valid again. The block is meant to sit in the pixel clock domain, in front of frame logic that expects sync markers. Pixel data does not pass through it.

Top module: `de_sync_regen`

## Requirements
- R1: A DE-high pixel clears the count of consecutive DE-low pixels, so the low pixels on either side of a DE-high pixel never add up to reach a threshold.
- R2: `hsync_stb` is high for exactly one cycle, one clock after the DE-low pixel with which the run first reaches `hgap_len`.
- R3: `vsync_stb` is high for exactly one cycle, one clock after the DE-low pixel with which the run first reaches `vgap_len`.
- R4: Each strobe fires at most once within one unbroken DE-low run, however long the run lasts. Inside that run, `vsync_stb` comes after `hsync_stb`.
- R5: The run counter saturates at 2^CW-1. A DE-low run longer than the counter range gives no further strobes.
- R6: `line_start` pulses for one cycle, one clock after the first DE-high pixel that follows a run that produced `hsync_stb`. A run shorter than `hgap_len` gives no `line_start`.
- R7: `frame_start` pulses in the same cycle as `line_start` when the run before it produced `vsync_stb`, and at no other time.
- R8: `config_error` goes high one clock after any pixel for which not (`hgap_len` > 1 and `hgap_len` < `vgap_len`). For those pixels all four pulse outputs stay low.
- R9: A new pair of gap lengths takes effect from the first pixel sampled with them. No reset is needed.
- R10: While `rst` is high and in the first cycle after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_in | input | 1 | Data Enable of the incoming pixel |
| hgap_len | input | CW | DE-low run length that produces a horizontal sync |
| vgap_len | input | CW | DE-low run length that produces a vertical sync |
| line_start | output | 1 | One-cycle marker of the first pixel of a line |
| frame_start | output | 1 | One-cycle marker of the first pixel of a frame |
| hsync_stb | output | 1 | One-cycle regenerated horizontal sync |
| vsync_stb | output | 1 | One-cycle regenerated vertical sync |
| config_error | output | 1 | Gap lengths break the ordering rule |

## Verification
Two properties rely on how the input behaves: that `frame_start` always comes with `line_start`, and that the strobes appear in order within a gap. Both assume the gap lengths change only while DE is high, because moving a threshold in the middle of a DE-low run could let the vertical sync fire before the horizontal one. The stimulus therefore loads every new configuration together with a DE-high pixel. It also keeps `vgap_len` within the counter range, so the vertical threshold can always be reached. Inside those limits, the stimulus covers short runs, runs that exactly reach each threshold, runs far longer than the counter range, a minimal legal setting, and three kinds of illegal setting.

// File: rtl/de_regen_pkg.sv
package de_regen_pkg;
  // Index of each sync level inside the per-level generate structure.
  localparam int LVL_H   = 0;
  localparam int LVL_V   = 1;
  localparam int NUM_LVL = 2;
endpackage

// File: rtl/dsr_run_counter.sv
// Saturating count of consecutive DE-low pixels.
module dsr_run_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_in,
  output logic [CW-1:0] run_next,
  output logic [CW-1:0] run_q
);
  localparam logic [CW-1:0] RUN_MAX = '1;

  always_comb begin
    if (de_in)
      run_next = '0;
    else if (run_q == RUN_MAX)
      run_next = run_q;
    else
      run_next = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_next;
  end
endmodule

// File: rtl/dsr_cfg_check.sv
// Validity of the threshold pair; registered error flag.
module dsr_cfg_check #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] hgap_len,
  input  logic [CW-1:0] vgap_len,
  output logic          cfg_ok,
  output logic          cfg_err_q
);
  localparam logic [CW-1:0] MIN_H = CW'(1);

  assign cfg_ok = (hgap_len > MIN_H) && (hgap_len < vgap_len);

  always_ff @(posedge clk) begin
    if (rst) cfg_err_q <= 1'b0;
    else     cfg_err_q <= !cfg_ok;
  end
endmodule

// File: rtl/dsr_level_track.sv
// One sync level: fires a strobe once per gap and marks the next active pixel.
module dsr_level_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_in,
  input  logic [CW-1:0] run_next,
  input  logic [CW-1:0] thr,
  input  logic          cfg_ok,
  output logic          strobe_q,
  output logic          start_q
);
  logic fired_q;
  logic hit;

  assign hit = !de_in && cfg_ok && !fired_q && (run_next >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      start_q  <= 1'b0;
      fired_q  <= 1'b0;
    end else begin
      strobe_q <= hit;
      start_q  <= de_in && fired_q && cfg_ok;
      if (de_in)    fired_q <= 1'b0;
      else if (hit) fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/de_sync_regen.sv
module de_sync_regen
  import de_regen_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_in,
  input  logic [CW-1:0] hgap_len,
  input  logic [CW-1:0] vgap_len,
  output logic          line_start,
  output logic          frame_start,
  output logic          hsync_stb,
  output logic          vsync_stb,
  output logic          config_error
);
  logic [CW-1:0] run_next;
  logic [CW-1:0] run_q;
  logic          cfg_ok;
  logic [CW-1:0] thr_arr [NUM_LVL];
  logic [NUM_LVL-1:0] strobe;
  logic [NUM_LVL-1:0] start;

  assign thr_arr[LVL_H] = hgap_len;
  assign thr_arr[LVL_V] = vgap_len;

  dsr_run_counter #(.CW(CW)) u_run (
    .clk(clk), .rst(rst), .de_in(de_in),
    .run_next(run_next), .run_q(run_q)
  );

  dsr_cfg_check #(.CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .hgap_len(hgap_len), .vgap_len(vgap_len),
    .cfg_ok(cfg_ok), .cfg_err_q(config_error)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    dsr_level_track #(.CW(CW)) u_trk (
      .clk(clk), .rst(rst), .de_in(de_in), .run_next(run_next),
      .thr(thr_arr[l]), .cfg_ok(cfg_ok),
      .strobe_q(strobe[l]), .start_q(start[l])
    );
  end

  assign hsync_stb   = strobe[LVL_H];
  assign vsync_stb   = strobe[LVL_V];
  assign line_start  = start[LVL_H];
  assign frame_start = start[LVL_V];
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          de_in,
  input logic [CW-1:0] run_q,
  input logic          line_start,
  input logic          frame_start,
  input logic          hsync_stb,
  input logic          vsync_stb,
  input logic          config_error
);
  localparam logic [CW-1:0] RUN_MAX = '1;

  assert_hsync_single_R4: assert property (@(posedge clk) disable iff (rst)
    hsync_stb |=> !hsync_stb);
  assert_vsync_single_R4: assert property (@(posedge clk) disable iff (rst)
    vsync_stb |=> !vsync_stb);
  assert_hsync_in_gap_R2: assert property (@(posedge clk) disable iff (rst)
    hsync_stb |-> !$past(de_in));
  assert_vsync_in_gap_R3: assert property (@(posedge clk) disable iff (rst)
    vsync_stb |-> !$past(de_in));
  assert_no_joint_sync_R4: assert property (@(posedge clk) disable iff (rst)
    !(hsync_stb && vsync_stb));
  assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (run_q == RUN_MAX && !de_in) |=> (run_q == RUN_MAX));
  assert_clear_on_de_R1: assert property (@(posedge clk) disable iff (rst)
    de_in |=> (run_q == '0));
  assert_line_after_de_R6: assert property (@(posedge clk) disable iff (rst)
    line_start |-> $past(de_in));
  assert_frame_with_line_R7: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);
  assert_err_mutes_R8: assert property (@(posedge clk) disable iff (rst)
    config_error |-> !(hsync_stb || vsync_stb || line_start || frame_start));
endmodule

bind de_sync_regen dsr_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .de_in(de_in), .run_q(run_q),
  .line_start(line_start), .frame_start(frame_start),
  .hsync_stb(hsync_stb), .vsync_stb(vsync_stb), .config_error(config_error)
);

// File: tb/de_sync_regen_tb.sv
module de_sync_regen_tb;
  localparam int CW = 8;
  localparam int RMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic de_in = 1'b1;
  logic [CW-1:0] hgap_len = '0;
  logic [CW-1:0] vgap_len = '0;
  logic line_start, frame_start, hsync_stb, vsync_stb, config_error;

  always #5 clk = ~clk;

  de_sync_regen #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .de_in(de_in), .hgap_len(hgap_len), .vgap_len(vgap_len),
    .line_start(line_start), .frame_start(frame_start),
    .hsync_stb(hsync_stb), .vsync_stb(vsync_stb), .config_error(config_error)
  );

  typedef struct {
    logic ls, fs, hs, vs, ce;
    string ph;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R10";
  int nh = 4, nv = 10;
  int run = 0;
  bit hf = 0, vf = 0;

  task automatic chk(logic act, logic exp, string ph, string nm);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", ph, nm, act, exp);
    end
  endtask

  // Driver: apply one pixel (and the pending config), push expected outputs.
  task automatic drive(bit de);
    exp_t e;
    bit ok;
    @(negedge clk);
    de_in = de;
    hgap_len = CW'(nh);
    vgap_len = CW'(nv);
    ok = (nh > 1) && (nh < nv);
    e.ph = phase;
    e.ce = !ok;
    e.ls = de && hf && ok;
    e.fs = de && vf && ok;
    if (de) begin
      run = 0; hf = 0; vf = 0; e.hs = 0; e.vs = 0;
    end else begin
      if (run < RMAX) run++;
      e.hs = ok && !hf && (run >= nh);
      e.vs = ok && !vf && (run >= nv);
      if (e.hs) hf = 1;
      if (e.vs) vf = 1;
    end
    sb.push_back(e);
  endtask

  task automatic pix(bit de, int n);
    for (int i = 0; i < n; i++) drive(de);
  endtask

  // Monitor: compare once outputs have settled after each edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(line_start,   e.ls, e.ph, "line_start");
      chk(frame_start,  e.fs, e.ph, "frame_start");
      chk(hsync_stb,    e.hs, e.ph, "hsync_stb");
      chk(vsync_stb,    e.vs, e.ph, "vsync_stb");
      chk(config_error, e.ce, e.ph, "config_error");
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: outputs low during reset
    repeat (3) @(posedge clk);
    #1;
    chk(line_start, 1'b0, "R10", "line_start");
    chk(frame_start, 1'b0, "R10", "frame_start");
    chk(hsync_stb, 1'b0, "R10", "hsync_stb");
    chk(vsync_stb, 1'b0, "R10", "vsync_stb");
    chk(config_error, 1'b0, "R10", "config_error");
    @(negedge clk);
    rst = 1'b0;
    phase = "R10 first cycle";
    pix(1, 2);
    // R6: short gap gives no line_start
    phase = "R6 short gap";
    pix(1, 8); pix(0, 3); pix(1, 8);
    // R2/R6: gap one above hgap
    phase = "R2 R6 hsync gap";
    pix(0, 5); pix(1, 8);
    // R1: DE-high pixel splits two short runs
    phase = "R1 run cleared";
    pix(0, 3); pix(1, 1); pix(0, 3); pix(1, 4);
    // R2: run exactly hgap
    phase = "R2 exact hgap";
    pix(0, 4); pix(1, 4);
    // R3/R7: vertical gap
    phase = "R3 R7 vsync gap";
    pix(0, 12); pix(1, 6);
    // R4: long gap, single strobes
    phase = "R4 long gap";
    pix(0, 40); pix(1, 4);
    // R5: gap beyond counter range with vgap at range top
    nv = RMAX;
    phase = "R5 saturation";
    pix(1, 2); pix(0, 600); pix(1, 4);
    // R8: illegal settings
    nh = 1; nv = 10;
    phase = "R8 hgap too small";
    pix(1, 2); pix(0, 20); pix(1, 3);
    nh = 10; nv = 10;
    phase = "R8 hgap equals vgap";
    pix(1, 2); pix(0, 20); pix(1, 3);
    nh = 12; nv = 6;
    phase = "R8 hgap above vgap";
    pix(1, 2); pix(0, 20); pix(1, 3);
    // R9: runtime change to minimal legal pair
    nh = 2; nv = 3;
    phase = "R9 minimal pair";
    pix(1, 2); pix(0, 3); pix(1, 3); pix(0, 1); pix(1, 2);
    nh = 6; nv = 20;
    phase = "R9 wider pair";
    pix(1, 2); pix(0, 5); pix(1, 2); pix(0, 7); pix(1, 2); pix(0, 21); pix(1, 3);
    phase = "drain";
    pix(1, 3);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule